// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block keeps an ordered queue of kernels that are waiting to be dispatched. It hands their workgroups, one per clock, to a compute-unit allocator. A producer registers a kernel by giving its identifier and its total number of workgroups. A kernel may not issue anything until its cache-invalidate phase has been reported finished. When the acquire feature is switched off, that phase is skipped.

Work happens in scheduling passes. A pass is started by one of three events: a kernel launch, an invalidate-done report, or a workgroup-completion pulse. Within a pass the scheduler looks at the kernel at the head of the queue and handles it in one of three ways:
- If it is still blocked by its invalidate, or the allocator refuses its workgroup, it is moved to the tail and counted as a failure for this pass.
- If it can issue, it issues workgroups in index order.
- Once its last workgroup is accepted, it leaves the queue.

A pass stops as soon as the number of queued kernels is no larger than the number of failures counted in that pass. This rule lets a kernel with modest resource needs overtake one that is stuck, without the scheduler spinning forever. A counter records how many passes began with work pending.

Top module: `wg_dispatch_sched`

## Requirements
- R1: After reset, `launch_ready` is 1, `wg_valid` is 0, `active` is 0 and `wait_passes` is 0.
- R2: A launch is accepted on a cycle where `launch_valid` and `launch_ready` are both high. While `DEPTH` kernels are queued, `launch_ready` stays low. `launch_ready` is also low while a pass is running.
- R3: When the allocator accepts every offer, a kernel issues workgroup indices 0, 1, … up to its total minus 1 on consecutive cycles. Kernels are served in launch order. The first offer for a kernel launched into an idle, empty queue appears in the cycle right after the launch is accepted.
- R4: With `acquire_en` high, a kernel offers no workgroup until an `inv_done_valid` pulse carrying its identifier arrives. The pass triggered by that pulse then issues the kernel's workgroups.
- R5: With `acquire_en` low, a kernel's invalidate is treated as complete, and it issues without any invalidate report.
- R6: When the allocator refuses an offer (`wg_ready` low while `wg_valid` is high), that kernel moves to the tail. Later kernels in the same pass may issue. The refused kernel later resumes at the same workgroup index.
- R7: A pass ends once the queue length is not greater than the failures counted in it. If every queued kernel is blocked, no workgroup is offered and the block returns to idle.
- R8: `wait_passes` increments by exactly one for each pass that starts with a non-empty queue. It does not change for a pass that starts with an empty queue.
- R9: A `wg_cmpl` pulse starts a new pass, which retries kernels that were previously refused.
- R10: `active` is high exactly while at least one kernel is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acquire_en | input | 1 | Kernel-launch acquire enable; when low, the invalidate phase is skipped |
| launch_valid | input | 1 | Launch request |
| launch_ready | output | 1 | Launch can be accepted |
| launch_kid | input | KID_W | Identifier of the launched kernel |
| launch_wg_total | input | WGC_W | Number of workgroups in the launched kernel |
| inv_done_valid | input | 1 | Invalidate-complete report |
| inv_done_kid | input | KID_W | Kernel whose invalidate completed |
| wg_cmpl | input | 1 | Workgroup-completion event (starts a pass) |
| wg_valid | output | 1 | Workgroup offered to the allocator |
| wg_ready | input | 1 | Allocator accepts the offer; low means refused |
| wg_kid | output | KID_W | Kernel of the offered workgroup |
| wg_index | output | WGC_W | Index of the offered workgroup within its kernel |
| active | output | 1 | At least one kernel queued |
| wait_passes | output | CNT_W | Count of passes that began with a non-empty queue |

## Verification
A corrupted queue pointer or a wrong per-kernel issued count shows up at the allocator port almost at once. It appears within the next pass, as a duplicated, skipped or out-of-order (kernel, index) pair. A wrong failure count or a wrong pass-end test shows up in one of two ways: the block keeps offering after all kernels are blocked, or it stops before a bypassing kernel gets its turn. The scoreboard sees either one within a few cycles of the triggering event. A stuck invalidate flag shows up as an offer that arrives before the invalidate report, or as one that never arrives after it.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  typedef enum logic [0:0] {
    PS_IDLE = 1'b0,
    PS_SCAN = 1'b1
  } pass_state_e;
endpackage

// File: rtl/wgd_kernel_ring.sv
// Circular queue of pending kernels with per-entry dispatch state.
module wgd_kernel_ring #(
  parameter int DEPTH = 4,
  parameter int KID_W = 4,
  parameter int WGC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [KID_W-1:0] push_kid,
  input  logic [WGC_W-1:0] push_tot,
  input  logic             push_inv,
  input  logic             pop_en,
  input  logic             rot_en,
  input  logic             inc_en,
  input  logic             mark_en,
  input  logic [KID_W-1:0] mark_kid,
  output logic [KID_W-1:0] head_kid,
  output logic [WGC_W-1:0] head_tot,
  output logic [WGC_W-1:0] head_iss,
  output logic             head_inv,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] PMAX = PW'(DEPTH-1);

  logic [KID_W-1:0] kid_q [DEPTH];
  logic [WGC_W-1:0] tot_q [DEPTH];
  logic [WGC_W-1:0] iss_q [DEPTH];
  logic [KID_W-1:0] kid_d [DEPTH];
  logic [WGC_W-1:0] tot_d [DEPTH];
  logic [WGC_W-1:0] iss_d [DEPTH];
  logic [DEPTH-1:0] inv_q, inv_d, occ_q, occ_d;
  logic [PW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PMAX) ? '0 : PW'(p + 1'b1);
  endfunction

  always_comb begin
    kid_d  = kid_q;
    tot_d  = tot_q;
    iss_d  = iss_q;
    inv_d  = inv_q;
    occ_d  = occ_q;
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (mark_en && occ_q[i] && (kid_q[i] == mark_kid)) inv_d[i] = 1'b1;
    end
    if (inc_en) iss_d[head_q] = iss_q[head_q] + 1'b1;
    if (pop_en) begin
      occ_d[head_q] = 1'b0;
      head_d        = ptr_inc(head_q);
      cnt_d         = cnt_q - 1'b1;
    end
    if (rot_en) begin
      occ_d[head_q] = 1'b0;
      kid_d[tail_q] = kid_q[head_q];
      tot_d[tail_q] = tot_q[head_q];
      iss_d[tail_q] = iss_q[head_q];
      inv_d[tail_q] = inv_d[head_q];
      occ_d[tail_q] = 1'b1;
      head_d        = ptr_inc(head_q);
      tail_d        = ptr_inc(tail_q);
    end
    if (push_en) begin
      kid_d[tail_q] = push_kid;
      tot_d[tail_q] = push_tot;
      iss_d[tail_q] = '0;
      inv_d[tail_q] = push_inv;
      occ_d[tail_q] = 1'b1;
      tail_d        = ptr_inc(tail_q);
      cnt_d         = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      occ_q  <= occ_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    kid_q <= kid_d;
    tot_q <= tot_d;
    iss_q <= iss_d;
    inv_q <= inv_d;
  end

  assign head_kid = kid_q[head_q];
  assign head_tot = tot_q[head_q];
  assign head_iss = iss_q[head_q];
  assign head_inv = inv_q[head_q];
  assign count    = cnt_q;
  assign full     = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (cnt_q != CW'(DEPTH)));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en || rot_en) |-> (cnt_q != '0));
  assert_rotate_keeps_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_en && !push_en) |=> (cnt_q == $past(cnt_q)));
  assert_occ_matches_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ_q) == int'(cnt_q));
endmodule

// File: rtl/wgd_pass_ctrl.sv
// Scheduling pass sequencer: head examination, failure count, wait counter.
module wgd_pass_ctrl
  import wgd_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WGC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic             head_ok,
  input  logic [WGC_W-1:0] head_iss,
  input  logic [WGC_W-1:0] head_tot,
  input  logic             wg_ready,
  output logic             scanning,
  output logic             wg_valid,
  output logic             pop_en,
  output logic             rot_en,
  output logic             inc_en,
  output logic [CNT_W-1:0] wait_passes
);
  localparam int CW = $clog2(DEPTH+1);

  pass_state_e     st_q, st_d;
  logic [CW-1:0]   fail_q, fail_d;
  logic            first_q, first_d, pend_q, pend_d;
  logic [CNT_W-1:0] wait_q, wait_d;
  logic            examine, last_wg;

  assign examine = (st_q == PS_SCAN) && (count > fail_q);
  assign last_wg = ({1'b0, head_iss} + 1'b1) == {1'b0, head_tot};

  always_comb begin
    st_d     = st_q;
    fail_d   = fail_q;
    first_d  = 1'b0;
    pend_d   = pend_q;
    wait_d   = wait_q;
    wg_valid = 1'b0;
    pop_en   = 1'b0;
    rot_en   = 1'b0;
    inc_en   = 1'b0;
    if (examine) begin
      if (!head_ok) begin
        rot_en = 1'b1;
        fail_d = fail_q + 1'b1;
      end else if (head_iss >= head_tot) begin
        pop_en = 1'b1;
      end else begin
        wg_valid = 1'b1;
        if (wg_ready) begin
          if (last_wg) pop_en = 1'b1;
          else         inc_en = 1'b1;
        end else begin
          rot_en = 1'b1;
          fail_d = fail_q + 1'b1;
        end
      end
    end
    if (st_q == PS_SCAN) begin
      if (first_q && (count != '0)) wait_d = wait_q + 1'b1;
      pend_d = pend_q | trigger;
      if (!examine) st_d = PS_IDLE;
    end else if (trigger || pend_q) begin
      st_d    = PS_SCAN;
      fail_d  = '0;
      first_d = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      fail_q  <= '0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
      wait_q  <= '0;
    end else begin
      st_q    <= st_d;
      fail_q  <= fail_d;
      first_q <= first_d;
      pend_q  <= pend_d;
      wait_q  <= wait_d;
    end
  end

  assign scanning    = (st_q == PS_SCAN);
  assign wait_passes = wait_q;

  assert_offer_in_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wg_valid |-> (st_q == PS_SCAN));
  assert_fail_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q <= CW'(DEPTH));
  assert_index_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wg_valid |-> (head_iss < head_tot));
  assert_wait_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q != wait_d) |-> (wait_d == wait_q + 1'b1));
endmodule

// File: rtl/wg_dispatch_sched.sv
module wg_dispatch_sched #(
  parameter int DEPTH = 4,
  parameter int KID_W = 4,
  parameter int WGC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acquire_en,
  input  logic             launch_valid,
  output logic             launch_ready,
  input  logic [KID_W-1:0] launch_kid,
  input  logic [WGC_W-1:0] launch_wg_total,
  input  logic             inv_done_valid,
  input  logic [KID_W-1:0] inv_done_kid,
  input  logic             wg_cmpl,
  output logic             wg_valid,
  input  logic             wg_ready,
  output logic [KID_W-1:0] wg_kid,
  output logic [WGC_W-1:0] wg_index,
  output logic             active,
  output logic [CNT_W-1:0] wait_passes
);
  localparam int CW = $clog2(DEPTH+1);

  logic             push_en, pop_en, rot_en, inc_en, full, scanning, head_inv;
  logic [KID_W-1:0] head_kid;
  logic [WGC_W-1:0] head_tot, head_iss;
  logic [CW-1:0]    count;
  logic             trigger;

  assign launch_ready = !scanning && !full;
  assign push_en      = launch_valid && launch_ready;
  assign trigger      = push_en || inv_done_valid || wg_cmpl;

  wgd_kernel_ring #(.DEPTH(DEPTH), .KID_W(KID_W), .WGC_W(WGC_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (push_en),
    .push_kid (launch_kid),
    .push_tot (launch_wg_total),
    .push_inv (!acquire_en),
    .pop_en   (pop_en),
    .rot_en   (rot_en),
    .inc_en   (inc_en),
    .mark_en  (inv_done_valid),
    .mark_kid (inv_done_kid),
    .head_kid (head_kid),
    .head_tot (head_tot),
    .head_iss (head_iss),
    .head_inv (head_inv),
    .count    (count),
    .full     (full)
  );

  wgd_pass_ctrl #(.DEPTH(DEPTH), .WGC_W(WGC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .trigger     (trigger),
    .count       (count),
    .head_ok     (head_inv || !acquire_en),
    .head_iss    (head_iss),
    .head_tot    (head_tot),
    .wg_ready    (wg_ready),
    .scanning    (scanning),
    .wg_valid    (wg_valid),
    .pop_en      (pop_en),
    .rot_en      (rot_en),
    .inc_en      (inc_en),
    .wait_passes (wait_passes)
  );

  assign wg_kid   = head_kid;
  assign wg_index = head_iss;
  assign active   = (count != '0);

  assert_full_blocks_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !launch_ready);
  assert_next_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wg_valid && wg_ready && inc_en) |=> (wg_valid && wg_index == $past(wg_index) + 1'b1));
endmodule

// File: tb/test_wg_dispatch_sched.sv
`timescale 1ns/1ps
module test_wg_dispatch_sched;
  localparam int DEPTH = 4;
  localparam int KID_W = 4;
  localparam int WGC_W = 8;
  localparam int CNT_W = 16;

  logic             clk, rst_n, acquire_en;
  logic             launch_valid, launch_ready;
  logic [KID_W-1:0] launch_kid, inv_done_kid, wg_kid;
  logic [WGC_W-1:0] launch_wg_total, wg_index;
  logic             inv_done_valid, wg_cmpl, wg_valid, wg_ready, active;
  logic [CNT_W-1:0] wait_passes;
  logic             blk_en;
  logic [KID_W-1:0] blk_kid;

  int n_cmp, n_bad, n_fires;
  logic [KID_W+WGC_W-1:0] exp_q [$];
  string                  tag_q [$];

  wg_dispatch_sched #(.DEPTH(DEPTH), .KID_W(KID_W), .WGC_W(WGC_W), .CNT_W(CNT_W)) i_wg_dispatch_sched (
    .clk(clk), .rst_n(rst_n), .acquire_en(acquire_en),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_kid(launch_kid), .launch_wg_total(launch_wg_total),
    .inv_done_valid(inv_done_valid), .inv_done_kid(inv_done_kid),
    .wg_cmpl(wg_cmpl), .wg_valid(wg_valid), .wg_ready(wg_ready),
    .wg_kid(wg_kid), .wg_index(wg_index), .active(active),
    .wait_passes(wait_passes)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign wg_ready = !(blk_en && wg_kid == blk_kid);

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_wg(input int kid, input int idx, input string req);
    exp_q.push_back({KID_W'(kid), WGC_W'(idx)});
    tag_q.push_back(req);
  endtask

  // Monitor: every accepted offer is compared with the scoreboard front
  always @(negedge clk) begin
    if (rst_n && wg_valid && wg_ready) begin
      n_fires++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected workgroup", int'({wg_kid, wg_index}), -1);
      end else begin
        logic [KID_W+WGC_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({wg_kid, wg_index} == e, t, int'({wg_kid, wg_index}), int'(e));
      end
    end
  end

  int wd_cnt;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      chk(1'b0, "watchdog", wd_cnt, 0);
      summary();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launch(input int kid, input int tot);
    while (!launch_ready) @(negedge clk);
    launch_valid    = 1'b1;
    launch_kid      = KID_W'(kid);
    launch_wg_total = WGC_W'(tot);
    @(negedge clk);
    launch_valid = 1'b0;
  endtask

  task automatic inv_done(input int kid);
    inv_done_valid = 1'b1;
    inv_done_kid   = KID_W'(kid);
    @(negedge clk);
    inv_done_valid = 1'b0;
  endtask

  task automatic cmpl_pulse();
    wg_cmpl = 1'b1;
    @(negedge clk);
    wg_cmpl = 1'b0;
  endtask

  initial begin
    int f0, w0;
    n_cmp = 0; n_bad = 0; n_fires = 0; wd_cnt = 0;
    rst_n = 1'b0; acquire_en = 1'b0; launch_valid = 1'b0;
    launch_kid = '0; launch_wg_total = '0; inv_done_valid = 1'b0;
    inv_done_kid = '0; wg_cmpl = 1'b0; blk_en = 1'b0; blk_kid = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(launch_ready == 1'b1, "R1 launch_ready", int'(launch_ready), 1);
    chk(wg_valid == 1'b0, "R1 wg_valid", int'(wg_valid), 0);
    chk(active == 1'b0, "R1 active", int'(active), 0);
    chk(wait_passes == '0, "R1 wait_passes", int'(wait_passes), 0);

    // R5 / R3: acquire disabled, in-order issue; first offer right after launch
    acquire_en = 1'b0;
    expect_wg(1, 0, "R3 k1 wg0"); expect_wg(1, 1, "R3 k1 wg1"); expect_wg(1, 2, "R3 k1 wg2");
    expect_wg(2, 0, "R5 k2 wg0"); expect_wg(2, 1, "R5 k2 wg1");
    launch(1, 3);
    chk(wg_valid && wg_kid == 1 && wg_index == 0, "R3 first offer latency",
        int'(wg_valid), 1);
    launch(2, 2);
    idle(6);
    chk(exp_q.size() == 0, "R3 all issued", exp_q.size(), 0);
    chk(active == 1'b0, "R10 drained", int'(active), 0);

    // R4: invalidate gating
    acquire_en = 1'b1;
    f0 = n_fires;
    launch(3, 2);
    idle(10);
    chk(n_fires == f0, "R4 no issue before invalidate", n_fires, f0);
    chk(active == 1'b1, "R10 pending", int'(active), 1);
    chk(launch_ready == 1'b1, "R7 pass ended when blocked", int'(launch_ready), 1);
    expect_wg(3, 0, "R4 k3 wg0"); expect_wg(3, 1, "R4 k3 wg1");
    inv_done(3);
    idle(6);
    chk(exp_q.size() == 0, "R4 issued after invalidate", exp_q.size(), 0);

    // R6 / R9: refusal rotates, later kernel bypasses, retry on completion
    acquire_en = 1'b0;
    blk_en = 1'b1; blk_kid = 4'd4;
    f0 = n_fires;
    launch(4, 2);
    idle(5);
    chk(n_fires == f0, "R6 refused kernel not issued", n_fires, f0);
    expect_wg(5, 0, "R6 k5 bypasses k4");
    launch(5, 1);
    idle(6);
    chk(exp_q.size() == 0, "R6 bypass done", exp_q.size(), 0);
    chk(active == 1'b1, "R6 k4 still queued", int'(active), 1);
    blk_en = 1'b0;
    expect_wg(4, 0, "R9 k4 wg0 retry"); expect_wg(4, 1, "R9 k4 wg1 retry");
    cmpl_pulse();
    idle(6);
    chk(exp_q.size() == 0, "R9 retry issued", exp_q.size(), 0);

    // R2 / R7 / R8: fill queue with blocked kernels
    acquire_en = 1'b1;
    f0 = n_fires;
    launch(6, 1); launch(7, 1); launch(8, 1); launch(9, 1);
    idle(12);
    chk(launch_ready == 1'b0, "R2 full blocks launch", int'(launch_ready), 0);
    chk(n_fires == f0, "R7 all blocked no offer", n_fires, f0);
    w0 = int'(wait_passes);
    expect_wg(8, 0, "R7 k8 found among blocked");
    inv_done(8);
    idle(8);
    chk(int'(wait_passes) == w0 + 1, "R8 one pass counted", int'(wait_passes), w0 + 1);
    chk(launch_ready == 1'b1, "R2 ready after pop", int'(launch_ready), 1);
    expect_wg(9, 0, "R7 k9");
    inv_done(9);
    idle(8);
    expect_wg(6, 0, "R7 k6");
    inv_done(6);
    idle(8);
    expect_wg(7, 0, "R7 k7");
    inv_done(7);
    idle(8);
    chk(exp_q.size() == 0, "R7 blocked set drained", exp_q.size(), 0);
    chk(active == 1'b0, "R10 empty", int'(active), 0);
    w0 = int'(wait_passes);
    cmpl_pulse();
    idle(4);
    chk(int'(wait_passes) == w0, "R8 empty pass not counted", int'(wait_passes), w0);

    summary();
    $finish;
  end
endmodule